// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator machine. It is purely combinational. Each evaluation takes the accumulator byte, a second operand byte, the current carry and auxiliary-carry flags, and a 4-bit operation code. It returns the result byte, the new carry (C), auxiliary carry (AC) and overflow (OV) values, and one write enable per flag. The enables tell the surrounding status register which flags the operation is allowed to change.

Addition comes in a plain form and a form that adds the incoming carry. Subtraction exists only in a form that also subtracts the carry as a borrow, so a plain subtract means clearing C first. Increment and decrement leave every flag alone. The bitwise operations, clear, complement, the plain rotates and the nibble swap also leave every flag alone. The two rotates through carry treat C as a ninth bit. A decimal-adjust operation corrects the sum of two packed BCD bytes, using the AC and C values produced by that addition.

Top module: `alu8_flags_top`

## Requirements
- R1: Operation codes are: 0 ADD, 1 ADDC, 2 SUBB, 3 INC, 4 DEC, 5 AND, 6 OR, 7 XOR, 8 CPL, 9 CLR, 10 RL, 11 RR, 12 RLC, 13 RRC, 14 SWAP, 15 DA. ADD gives result = (A + B) mod 256, and all three flag enables are high. C is set when the 9-bit sum exceeds FFh. AC is set on a carry out of bit 3. OV is set when exactly one of the carries out of bit 6 and bit 7 occurs (3Fh + D3h gives 12h with C=1, AC=1, OV=0).
- R2: ADDC behaves as ADD but also adds the incoming carry to the sum and to the low-nibble sum.
- R3: SUBB gives result = (A − B − C) mod 256, and all three enables are high. C is set on a borrow out of bit 7. AC is set when the low nibble of A is less than the low nibble of B plus C. OV is set when A − B − C, taken as signed bytes, falls outside −128..127.
- R4: INC gives (A + 1) mod 256 and DEC gives (A − 1) mod 256. All flag enables are low for both.
- R5: AND, OR and XOR combine A with B bitwise. CPL gives the bitwise inverse of A. CLR gives 00h. All flag enables are low for these five.
- R6: RL rotates A left by one, with bit 7 going to bit 0. RR rotates A right by one, with bit 0 going to bit 7. All flag enables are low.
- R7: RLC gives {A[6:0], C} and a new C of A[7]. RRC gives {C, A[7:1]} and a new C of A[0]. Only the C enable is high.
- R8: SWAP exchanges the two nibbles of A (72h gives 27h). All flag enables are low.
- R9: DA first adds 06h when A[3:0] > 9 or AC = 1. It then adds 60h when the high nibble of that value is above 9, when C = 1, or when the first step carried out. The new C is the incoming C OR'd with any carry out of either step, so DA never clears C. Only the C enable is high (23h + 29h = 4Ch adjusts to 52h).
- R10: When a flag's enable is low, its output repeats the incoming value: carryOut equals carryIn and auxCarryOut equals auxCarryIn. ovOut is 0 whenever its enable is low.
- R11: All outputs depend only on the present inputs and hold no state; they are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | Accumulator operand |
| opB | input | 8 | Second operand byte |
| aluOp | input | 4 | Operation code (see R1) |
| carryIn | input | 1 | Current carry flag |
| auxCarryIn | input | 1 | Current auxiliary carry flag |
| result | output | 8 | Result byte |
| carryOut | output | 1 | New carry value |
| auxCarryOut | output | 1 | New auxiliary carry value |
| ovOut | output | 1 | New overflow value |
| cWe | output | 1 | Carry may be written |
| acWe | output | 1 | Auxiliary carry may be written |
| ovWe | output | 1 | Overflow may be written |

## Verification
No register lies between any input and any output, so every result and flag is due in the same cycle as its stimulus. The bench changes the inputs on the falling clock edge and samples all seven outputs one nanosecond later, well before the next rising edge. It compares them with a reference model written in integer arithmetic. That model finds overflow from signed value ranges rather than from carries, so it does not share structure with the adder. Directed vectors cover the worked sum, the BCD adjust examples, wrap-around at 00h and FFh, and signed overflow in both directions. A seeded random run covers all sixteen operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;
  localparam int BCD_MAX = 9;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUBB = 4'd2,  OP_INC  = 4'd3,
    OP_DEC  = 4'd4,  OP_AND  = 4'd5,  OP_OR   = 4'd6,  OP_XOR  = 4'd7,
    OP_CPL  = 4'd8,  OP_CLR  = 4'd9,  OP_RL   = 4'd10, OP_RR   = 4'd11,
    OP_RLC  = 4'd12, OP_RRC  = 4'd13, OP_SWAP = 4'd14, OP_DA   = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {B_OPER, B_ZERO, B_ONES} bSel_e;
  typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_FLAG, CI_NFLAG} ciSel_e;
  typedef enum logic [2:0] {RES_ADDER, RES_LOGIC, RES_ROT, RES_SWAP, RES_DA} resSel_e;
  typedef enum logic [2:0] {LG_AND, LG_OR, LG_XOR, LG_NOT, LG_ZERO} logicOp_e;
  typedef enum logic [1:0] {ROT_L, ROT_R, ROT_LC, ROT_RC} rotOp_e;
  typedef enum logic [1:0] {CSRC_ADD, CSRC_ROT, CSRC_DA} cSrc_e;

  typedef struct packed {
    bSel_e    bSel;
    ciSel_e   ciSel;
    logic     subMode;
    resSel_e  resSel;
    logicOp_e logicOp;
    rotOp_e   rotOp;
    cSrc_e    cSrc;
    logic     cWe;
    logic     acWe;
    logic     ovWe;
  } aluCtrl_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  aluOp_e   op,
  output aluCtrl_t ctrl
);
  always_comb begin
    ctrl = '{bSel: B_OPER, ciSel: CI_ZERO, subMode: 1'b0, resSel: RES_ADDER,
             logicOp: LG_AND, rotOp: ROT_L, cSrc: CSRC_ADD,
             cWe: 1'b0, acWe: 1'b0, ovWe: 1'b0};
    unique case (op)
      OP_ADD: begin
        ctrl.cWe = 1'b1; ctrl.acWe = 1'b1; ctrl.ovWe = 1'b1;
      end
      OP_ADDC: begin
        ctrl.ciSel = CI_FLAG;
        ctrl.cWe = 1'b1; ctrl.acWe = 1'b1; ctrl.ovWe = 1'b1;
      end
      OP_SUBB: begin
        ctrl.ciSel = CI_NFLAG;
        ctrl.subMode = 1'b1;
        ctrl.cWe = 1'b1; ctrl.acWe = 1'b1; ctrl.ovWe = 1'b1;
      end
      OP_INC: begin
        ctrl.bSel = B_ZERO; ctrl.ciSel = CI_ONE;
      end
      OP_DEC: begin
        ctrl.bSel = B_ONES; ctrl.ciSel = CI_ZERO;
      end
      OP_AND: begin ctrl.resSel = RES_LOGIC; ctrl.logicOp = LG_AND;  end
      OP_OR:  begin ctrl.resSel = RES_LOGIC; ctrl.logicOp = LG_OR;   end
      OP_XOR: begin ctrl.resSel = RES_LOGIC; ctrl.logicOp = LG_XOR;  end
      OP_CPL: begin ctrl.resSel = RES_LOGIC; ctrl.logicOp = LG_NOT;  end
      OP_CLR: begin ctrl.resSel = RES_LOGIC; ctrl.logicOp = LG_ZERO; end
      OP_RL:  begin ctrl.resSel = RES_ROT; ctrl.rotOp = ROT_L; end
      OP_RR:  begin ctrl.resSel = RES_ROT; ctrl.rotOp = ROT_R; end
      OP_RLC: begin
        ctrl.resSel = RES_ROT; ctrl.rotOp = ROT_LC;
        ctrl.cSrc = CSRC_ROT; ctrl.cWe = 1'b1;
      end
      OP_RRC: begin
        ctrl.resSel = RES_ROT; ctrl.rotOp = ROT_RC;
        ctrl.cSrc = CSRC_ROT; ctrl.cWe = 1'b1;
      end
      OP_SWAP: ctrl.resSel = RES_SWAP;
      OP_DA: begin
        ctrl.resSel = RES_DA; ctrl.cSrc = CSRC_DA; ctrl.cWe = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_bcd_adjust.sv
module alu8_bcd_adjust
  import alu8_pkg::*;
(
  input  logic [DATA_W-1:0] valIn,
  input  logic              carryIn,
  input  logic              auxCarryIn,
  output logic [DATA_W-1:0] valOut,
  output logic              carryOut
);
  localparam logic [DATA_W:0] LOW_FIX  = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HIGH_FIX = (DATA_W+1)'(6) << NIB_W;

  logic            lowAdj, highAdj;
  logic [DATA_W:0] step1, step2;

  always_comb begin
    lowAdj  = (valIn[NIB_W-1:0] > NIB_W'(BCD_MAX)) || auxCarryIn;
    step1   = {1'b0, valIn} + (lowAdj ? LOW_FIX : '0);
    highAdj = (step1[DATA_W-1:NIB_W] > NIB_W'(BCD_MAX)) || carryIn || step1[DATA_W];
    step2   = {1'b0, step1[DATA_W-1:0]} + (highAdj ? HIGH_FIX : '0);
    valOut  = step2[DATA_W-1:0];
    // the adjust can only raise the carry, never drop it
    carryOut = carryIn | step1[DATA_W] | step2[DATA_W];
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
(
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              auxCarryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryNew,
  output logic              auxNew,
  output logic              ovNew
);
  localparam int MSB = DATA_W - 1;

  // shared adder: subtraction runs as A + ~B + ~C
  logic [DATA_W-1:0] bVal, bEff;
  logic              cinBit;
  logic [DATA_W:0]   sumFull;
  logic              carryIntoMsb, carryOutMsb, carryOutNib;

  always_comb begin
    unique case (ctrl.bSel)
      B_ZERO:  bVal = '0;
      B_ONES:  bVal = '1;
      default: bVal = opB;
    endcase
    bEff = ctrl.subMode ? ~bVal : bVal;
    unique case (ctrl.ciSel)
      CI_ONE:   cinBit = 1'b1;
      CI_FLAG:  cinBit = carryIn;
      CI_NFLAG: cinBit = ~carryIn;
      default:  cinBit = 1'b0;
    endcase
    sumFull      = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, cinBit};
    carryOutMsb  = sumFull[DATA_W];
    carryIntoMsb = sumFull[MSB] ^ opA[MSB] ^ bEff[MSB];
    carryOutNib  = sumFull[NIB_W] ^ opA[NIB_W] ^ bEff[NIB_W];
  end

  // bitwise unit
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    unique case (ctrl.logicOp)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      LG_NOT:  logicRes = ~opA;
      default: logicRes = '0;
    endcase
  end

  // rotate networks, one wire per bit
  logic [DATA_W-1:0] rotLeft, rotRight;
  for (genvar i = 0; i < DATA_W; i++) begin : g_rot
    assign rotLeft[i]  = opA[(i + DATA_W - 1) % DATA_W];
    assign rotRight[i] = opA[(i + 1) % DATA_W];
  end

  logic [DATA_W-1:0] rotRes;
  logic              rotCarry;
  always_comb begin
    unique case (ctrl.rotOp)
      ROT_L:   rotRes = rotLeft;
      ROT_R:   rotRes = rotRight;
      ROT_LC:  rotRes = {rotLeft[MSB:1], carryIn};
      default: rotRes = {carryIn, rotRight[MSB-1:0]};
    endcase
    rotCarry = (ctrl.rotOp == ROT_LC) ? opA[MSB] : opA[0];
  end

  logic [DATA_W-1:0] swapRes;
  assign swapRes = {opA[NIB_W-1:0], opA[DATA_W-1:NIB_W]};

  logic [DATA_W-1:0] daRes;
  logic              daCarry;
  alu8_bcd_adjust bcd_i (
    .valIn      (opA),
    .carryIn    (carryIn),
    .auxCarryIn (auxCarryIn),
    .valOut     (daRes),
    .carryOut   (daCarry)
  );

  always_comb begin
    unique case (ctrl.resSel)
      RES_LOGIC: result = logicRes;
      RES_ROT:   result = rotRes;
      RES_SWAP:  result = swapRes;
      RES_DA:    result = daRes;
      default:   result = sumFull[DATA_W-1:0];
    endcase
    unique case (ctrl.cSrc)
      CSRC_ROT: carryNew = rotCarry;
      CSRC_DA:  carryNew = daCarry;
      default:  carryNew = carryOutMsb ^ ctrl.subMode;
    endcase
    auxNew = carryOutNib ^ ctrl.subMode;
    ovNew  = carryIntoMsb ^ carryOutMsb;
  end
endmodule

// File: rtl/alu8_flags_top.sv
module alu8_flags_top
  import alu8_pkg::*;
(
  input  logic [7:0] opA,
  input  logic [7:0] opB,
  input  logic [3:0] aluOp,
  input  logic       carryIn,
  input  logic       auxCarryIn,
  output logic [7:0] result,
  output logic       carryOut,
  output logic       auxCarryOut,
  output logic       ovOut,
  output logic       cWe,
  output logic       acWe,
  output logic       ovWe
);
  aluCtrl_t ctrl;
  logic     carryNew, auxNew, ovNew;

  alu8_ctrl ctrl_i (
    .op   (aluOp_e'(aluOp)),
    .ctrl (ctrl)
  );

  alu8_datapath dp_i (
    .ctrl       (ctrl),
    .opA        (opA),
    .opB        (opB),
    .carryIn    (carryIn),
    .auxCarryIn (auxCarryIn),
    .result     (result),
    .carryNew   (carryNew),
    .auxNew     (auxNew),
    .ovNew      (ovNew)
  );

  assign cWe         = ctrl.cWe;
  assign acWe        = ctrl.acWe;
  assign ovWe        = ctrl.ovWe;
  assign carryOut    = ctrl.cWe  ? carryNew : carryIn;
  assign auxCarryOut = ctrl.acWe ? auxNew   : auxCarryIn;
  assign ovOut       = ctrl.ovWe & ovNew;
endmodule

// File: rtl/alu8_flags_checker.sv
module alu8_flags_checker
  import alu8_pkg::*;
(
  input logic [7:0] opA,
  input logic [7:0] opB,
  input logic [3:0] aluOp,
  input logic       carryIn,
  input logic       auxCarryIn,
  input logic [7:0] result,
  input logic       carryOut,
  input logic       auxCarryOut,
  input logic       ovOut,
  input logic       cWe,
  input logic       acWe,
  input logic       ovWe
);
  always_comb begin
    if (aluOp == OP_ADD)
      a_r1_add_sum: assert ({carryOut, result} == {1'b0, opA} + {1'b0, opB})
        else $error("R1 sum mismatch");
    if (aluOp == OP_ADDC)
      a_r2_addc_sum: assert ({carryOut, result} == {1'b0, opA} + {1'b0, opB} + {8'd0, carryIn})
        else $error("R2 sum mismatch");
    if (aluOp == OP_SUBB)
      a_r3_subb_diff: assert (result == opA - opB - {7'd0, carryIn})
        else $error("R3 difference mismatch");
    if (aluOp == OP_INC || aluOp == OP_DEC)
      a_r4_incdec_no_flags: assert (!(cWe || acWe || ovWe))
        else $error("R4 flag enable raised");
    if (aluOp >= OP_AND && aluOp <= OP_CLR)
      a_r5_logic_no_flags: assert (!(cWe || acWe || ovWe))
        else $error("R5 flag enable raised");
    if (aluOp == OP_RLC)
      a_r7_rlc_ninth_bit: assert ({carryOut, result} == {opA, carryIn})
        else $error("R7 rotate-through-carry mismatch");
    if (aluOp == OP_SWAP)
      a_r8_swap_nibbles: assert (result == {opA[3:0], opA[7:4]} && !cWe)
        else $error("R8 swap mismatch");
    if (aluOp == OP_DA && carryIn)
      a_r9_da_keeps_carry: assert (carryOut)
        else $error("R9 carry dropped");
    a_r10_passthrough: assert ((cWe || carryOut == carryIn) &&
                               (acWe || auxCarryOut == auxCarryIn) &&
                               (ovWe || !ovOut))
      else $error("R10 disabled flag changed");
  end
endmodule

bind alu8_flags_top alu8_flags_checker chk_i (
  .opA(opA), .opB(opB), .aluOp(aluOp), .carryIn(carryIn), .auxCarryIn(auxCarryIn),
  .result(result), .carryOut(carryOut), .auxCarryOut(auxCarryOut), .ovOut(ovOut),
  .cWe(cWe), .acWe(acWe), .ovWe(ovWe)
);

// File: tb/alu8_flags_top_tb_top.sv
module alu8_flags_top_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [7:0] opA = '0, opB = '0, result;
  logic [3:0] aluOp = '0;
  logic carryIn = 1'b0, auxCarryIn = 1'b0;
  logic carryOut, auxCarryOut, ovOut, cWe, acWe, ovWe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu8_flags_top dut_i (
    .opA(opA), .opB(opB), .aluOp(aluOp), .carryIn(carryIn), .auxCarryIn(auxCarryIn),
    .result(result), .carryOut(carryOut), .auxCarryOut(auxCarryOut), .ovOut(ovOut),
    .cWe(cWe), .acWe(acWe), .ovWe(ovWe)
  );

  typedef struct packed {
    logic [7:0] res;
    logic c, ac, ov, cwe, acwe, ovwe;
  } exp_t;

  function automatic int sgn(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic string reqOf(int op);
    case (op)
      0: return "R1";  1: return "R2";  2: return "R3";
      3, 4: return "R4";
      5, 6, 7, 8, 9: return "R5";
      10, 11: return "R6";
      12, 13: return "R7";
      14: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t model(int op, int a, int b, int c, int ac);
    exp_t e;
    int s, sv, r, nc, nac, nov, cw, aw, ow, c1;
    r = 0; nc = 0; nac = 0; nov = 0; cw = 0; aw = 0; ow = 0;
    case (op)
      0, 1: begin
        int ci = (op == 1) ? c : 0;
        s = a + b + ci; r = s % 256; nc = (s > 255);
        nac = (((a % 16) + (b % 16) + ci) > 15);
        sv = sgn(a) + sgn(b) + ci; nov = (sv > 127 || sv < -128);
        cw = 1; aw = 1; ow = 1;
      end
      2: begin
        s = a - b - c; r = (s + 512) % 256; nc = (s < 0);
        nac = (((a % 16) - (b % 16) - c) < 0);
        sv = sgn(a) - sgn(b) - c; nov = (sv > 127 || sv < -128);
        cw = 1; aw = 1; ow = 1;
      end
      3: r = (a + 1) % 256;
      4: r = (a + 255) % 256;
      5: r = a & b;
      6: r = a | b;
      7: r = a ^ b;
      8: r = 255 - a;
      9: r = 0;
      10: r = ((a * 2) % 256) + (a / 128);
      11: r = (a / 2) + (a % 2) * 128;
      12: begin r = ((a * 2) % 256) + c; nc = a / 128; cw = 1; end
      13: begin r = (a / 2) + c * 128; nc = a % 2; cw = 1; end
      14: r = ((a % 16) * 16) + (a / 16);
      default: begin
        s = a;
        if ((a % 16) > 9 || ac) s = s + 6;
        c1 = (s > 255); s = s % 256;
        if ((s / 16) > 9 || c || c1) s = s + 96;
        nc = (c || c1 || s > 255); r = s % 256; cw = 1;
      end
    endcase
    e.res  = r[7:0];
    e.cwe  = cw[0]; e.acwe = aw[0]; e.ovwe = ow[0];
    e.c    = cw[0] ? nc[0]  : c[0];
    e.ac   = aw[0] ? nac[0] : ac[0];
    e.ov   = ow[0] ? nov[0] : 1'b0;
    return e;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R11: inputs change on the falling edge; the combinational outputs are
  // sampled 1 ns later in the same cycle, away from either clock edge.
  task automatic runVec(int op, int a, int b, int c, int ac);
    exp_t e;
    string rq, rf;
    @(negedge clk);
    aluOp = op[3:0]; opA = a[7:0]; opB = b[7:0];
    carryIn = c[0]; auxCarryIn = ac[0];
    #1;
    e = model(op, a, b, c, ac);
    rq = reqOf(op);
    chk(rq, "result", int'(result), int'(e.res));
    chk(rq, "cWe",  int'(cWe),  int'(e.cwe));
    chk(rq, "acWe", int'(acWe), int'(e.acwe));
    chk(rq, "ovWe", int'(ovWe), int'(e.ovwe));
    rf = e.cwe ? rq : "R10";
    chk(rf, "carry", int'(carryOut), int'(e.c));
    rf = e.acwe ? rq : "R10";
    chk(rf, "auxCarry", int'(auxCarryOut), int'(e.ac));
    rf = e.ovwe ? rq : "R10";
    chk(rf, "overflow", int'(ovOut), int'(e.ov));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedv;
    seedv = $urandom(32'h1d5e);
    // idle state: all-zero inputs give a zero ADD (R1, R11)
    #1;
    chk("R1", "idle result", int'(result), 0);
    chk("R1", "idle carry", int'(carryOut), 0);
    // R1 worked sum 3F + D3 = 12, C=1 AC=1 OV=0
    runVec(0, 'h3F, 'hD3, 0, 0);
    runVec(0, 'h7F, 'h73, 0, 0);   // R1 positive overflow
    runVec(0, 'h8F, 'hD3, 0, 0);   // R1 negative overflow
    runVec(1, 'hFF, 'h00, 1, 0);   // R2 carry ripples through
    runVec(1, 'h0F, 'h00, 1, 0);   // R2 carry into bit 4
    runVec(2, 'h00, 'h01, 0, 0);   // R3 borrow out
    runVec(2, 'h80, 'h01, 0, 0);   // R3 signed overflow
    runVec(2, 'h50, 'h4F, 1, 1);   // R3 borrow as subtrahend
    runVec(3, 'hFF, 'h12, 1, 1);   // R4 wrap, flags carried
    runVec(4, 'h00, 'h34, 0, 1);   // R4 wrap
    runVec(5, 'h0F, 'hAC, 1, 0);   // R5
    runVec(8, 'hAC, 'h00, 0, 1);   // R5
    runVec(9, 'h5A, 'h00, 1, 1);   // R5
    runVec(10, 'hF0, 0, 0, 0);     // R6
    runVec(11, 'hF0, 0, 1, 0);     // R6
    runVec(13, 'hBD, 0, 0, 0);     // R7 -> 5E, C=1
    runVec(12, 'h3C, 0, 1, 0);     // R7 -> 79, C=0
    runVec(14, 'h72, 0, 0, 0);     // R8 -> 27
    runVec(15, 'h4C, 0, 0, 0);     // R9 -> 52
    runVec(15, 'h99, 0, 0, 0);     // R9 no adjust
    runVec(15, 'h9A, 0, 0, 0);     // R9 both nibbles, carry out
    runVec(15, 'h12, 0, 1, 1);     // R9 C kept, AC forces low fix
    for (int i = 0; i < 4000; i++)
      runVec(int'($urandom % 16), int'($urandom % 256), int'($urandom % 256),
             int'($urandom % 2), int'($urandom % 2));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule